// File: doc/BRIEF.md
# Flow-Through SEC-DED Memory Word Protector

This purely combinational unit sits between two 16-bit user data buses and a memory port. The memory port carries 16 data bits and 8 check-bit lines. On a write it forms a checkword from the user word and presents both toward memory. On a read it regenerates the checkword from the returned data and XORs it with the stored check bits to form a syndrome. It then repairs any single flipped bit and reports through two active-low flags, one for a repaired error and one for an error it cannot repair.

A width select chooses a 6-bit checkword (22-bit stored word) or an 8-bit checkword (24-bit stored word). Every column of the parity-check matrix has odd weight and no two columns are equal. This makes every double error visible. Within each aligned group of four stored bits, the four columns XOR to a nonzero value, so any error confined to one 4-bit memory device is reported.

A two-bit path select steers traffic: user A to memory, user B to memory, memory to one user bus, or user bus to user bus. In snoop mode a read is checked and flagged but neither user bus is driven, so the unit can watch another master's memory traffic. Each bus has its own output enable.

Top module: `edac16_ft`

## Requirements
- R1: With path 0 (A to memory) or path 1 (B to memory), the data output equals the selected user input, and the data and check enables are high while both user enables are low. Check bit j is the XOR of all data bits whose column has bit j set. The 6-bit columns for data bits 0 to 15 are hex 07, 0B, 0D, 0E, 13, 15, 16, 19, 1A, 1C, 23, 26, 29, 2A, 2C, 31. With the 8-bit checkword, bits 7:6 of the column are 00 for data bits 0 to 7 and 11 for data bits 8 to 15.
- R2: With the 6-bit checkword (wide_chk = 0), check outputs 7:6 are zero on a write, and check inputs 7:6 have no effect on read data or flags.
- R3: On a read (path 2) whose syndrome is zero, the returned word equals the memory data and both flags are high.
- R4: On a read with exactly one flipped data bit, the returned word equals the original data, cerr_n is low and uerr_n is high.
- R5: On a read with exactly one flipped check bit, the returned word equals the memory data, cerr_n is low and uerr_n is high.
- R6: On a read with exactly two flipped bits anywhere in the stored word, uerr_n is low and cerr_n is high. The returned word is the memory data unchanged.
- R7: In either width, any nonzero error pattern confined to one aligned 4-bit group of the stored word drives at least one flag low. Stored bits 0 to 15 are data and bits 16 to 23 are check bits 0 to 7.
- R8: On a read without snoop, to_b selects the user bus that is driven with the corrected word (1 = B, 0 = A). The memory data and check enables are low. On any path other than a read, both flags are high.
- R9: On a read with snoop high, no user bus and no memory line is driven, and the flags still report the syndrome.
- R10: With path 3, to_b = 1 copies A onto B and to_b = 0 copies B onto A. Only the destination bus is enabled, and memory is not driven.
- R11: The two flags are never low together, and the two user-bus enables are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wide_chk | input | 1 | 1 = 8-bit checkword, 0 = 6-bit checkword |
| path | input | 2 | 0 A to memory, 1 B to memory, 2 memory read, 3 user to user |
| to_b | input | 1 | Read destination or transfer direction (1 = toward B) |
| snoop | input | 1 | Read without driving either user bus |
| a_in | input | 16 | User bus A, incoming value |
| a_out | output | 16 | User bus A, value driven by the unit |
| a_oe | output | 1 | Drive enable for user bus A |
| b_in | input | 16 | User bus B, incoming value |
| b_out | output | 16 | User bus B, value driven by the unit |
| b_oe | output | 1 | Drive enable for user bus B |
| m_in | input | 16 | Memory data returned on a read |
| m_out | output | 16 | Memory data driven on a write |
| m_oe | output | 1 | Drive enable for memory data |
| k_in | input | 8 | Stored check bits returned on a read |
| k_out | output | 8 | Check bits driven on a write |
| k_oe | output | 1 | Drive enable for check bits |
| cerr_n | output | 1 | Low when a single-bit error was repaired |
| uerr_n | output | 1 | Low when an error was detected but not repaired |

## Verification
In both widths the bench goes through every single-bit position, every pair of positions, and every nonzero pattern inside each 4-bit group, over a spread of data words. Each stored word is compared against an encoder the bench builds from the column table. A matrix with a repeated or even-weight column would show up here as a double error that is mis-repaired under cerr_n, or as a 4-bit device failure that goes unflagged. A repair path that ignores check-bit hits would raise uerr_n on a lone check-bit flip. The bench also keeps garbage on the two unused check lines in 6-bit mode, so a design that reads those lines reports phantom errors. Steering is checked with deliberately corrupt memory data present, so a design that flags or drives memory outside a read gets caught.

// File: rtl/edac16_ft.sv
`timescale 1ns/1ps
module edac16_ft (
  input  logic        wide_chk,
  input  logic [1:0]  path,
  input  logic        to_b,
  input  logic        snoop,
  input  logic [15:0] a_in,
  output logic [15:0] a_out,
  output logic        a_oe,
  input  logic [15:0] b_in,
  output logic [15:0] b_out,
  output logic        b_oe,
  input  logic [15:0] m_in,
  output logic [15:0] m_out,
  output logic        m_oe,
  input  logic [7:0]  k_in,
  output logic [7:0]  k_out,
  output logic        k_oe,
  output logic        cerr_n,
  output logic        uerr_n
);
  localparam int DW = 16;
  localparam int KW = 8;
  localparam logic [1:0] P_A2M = 2'd0, P_B2M = 2'd1, P_RD = 2'd2, P_XFER = 2'd3;

  function automatic logic [KW-1:0] col(input int i, input logic w);
    logic [5:0] c;
    case (i)
      0: c = 6'h07;  1: c = 6'h0B;  2: c = 6'h0D;  3: c = 6'h0E;
      4: c = 6'h13;  5: c = 6'h15;  6: c = 6'h16;  7: c = 6'h19;
      8: c = 6'h1A;  9: c = 6'h1C; 10: c = 6'h23; 11: c = 6'h26;
      12: c = 6'h29; 13: c = 6'h2A; 14: c = 6'h2C; 15: c = 6'h31;
      default: c = 6'h00;
    endcase
    return {(w && i >= 8) ? 2'b11 : 2'b00, c};
  endfunction

  function automatic logic [KW-1:0] gen(input logic [DW-1:0] d, input logic w);
    logic [KW-1:0] g;
    g = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) g = g ^ col(i, w);
    return g;
  endfunction

  logic          rd, xfer, wr;
  logic [DW-1:0] src, flip, fixed;
  logic [KW-1:0] kmask, syn;
  logic          kbit_hit, repaired;

  assign rd    = (path == P_RD);
  assign xfer  = (path == P_XFER);
  assign wr    = (path == P_A2M) || (path == P_B2M);
  assign src   = (path == P_B2M) ? b_in : a_in;
  assign kmask = wide_chk ? 8'hFF : 8'h3F;
  assign syn   = gen(m_in, wide_chk) ^ (k_in & kmask);

  always_comb begin
    for (int i = 0; i < DW; i++)
      flip[i] = (syn == col(i, wide_chk));
  end

  assign kbit_hit = ($countones(syn) == 1);
  assign repaired = (|flip) || kbit_hit;
  assign fixed    = m_in ^ flip;

  assign cerr_n = !(rd && repaired);
  assign uerr_n = !(rd && (syn != '0) && !repaired);

  assign m_out = src;
  assign k_out = gen(src, wide_chk);
  assign m_oe  = wr;
  assign k_oe  = wr;

  assign a_out = rd ? fixed : b_in;
  assign b_out = rd ? fixed : a_in;
  assign a_oe  = (rd && !snoop && !to_b) || (xfer && !to_b);
  assign b_oe  = (rd && !snoop && to_b) || (xfer && to_b);

  always_comb begin
    AST_BUS_SINGLE: assert (!(a_oe && b_oe)) else $error("both user buses driven"); // R11
    AST_FLAG_EXCL: assert (!(!cerr_n && !uerr_n)) else $error("both flags low"); // R11
    if (rd || xfer)
      AST_MEM_QUIET: assert (!m_oe && !k_oe) else $error("memory driven off write"); // R8
    if (!rd)
      AST_FLAG_IDLE: assert (cerr_n && uerr_n) else $error("flag outside read"); // R8
    if (!wide_chk)
      AST_SIX_TOP: assert (k_out[7:6] == 2'b00) else $error("unused check lines set"); // R2
    if (rd && syn == '0)
      AST_CLEAN: assert (cerr_n && uerr_n && fixed == m_in) else $error("clean word altered"); // R3
  end
endmodule

// File: tb/edac16_ft_test.sv
`timescale 1ns/1ps
module edac16_ft_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wide_chk, to_b, snoop;
  logic [1:0]  path;
  logic [15:0] a_in, b_in, m_in, a_out, b_out, m_out;
  logic [7:0]  k_in, k_out;
  logic        a_oe, b_oe, m_oe, k_oe, cerr_n, uerr_n;
  int          n_cmp = 0;
  int          n_bad = 0;

  edac16_ft uut (
    .wide_chk(wide_chk), .path(path), .to_b(to_b), .snoop(snoop),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .m_in(m_in), .m_out(m_out), .m_oe(m_oe),
    .k_in(k_in), .k_out(k_out), .k_oe(k_oe),
    .cerr_n(cerr_n), .uerr_n(uerr_n)
  );

  localparam logic [5:0] TBL [16] = '{6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
                                      6'h1A, 6'h1C, 6'h23, 6'h26, 6'h29, 6'h2A, 6'h2C, 6'h31};

  function automatic logic [7:0] rgen(input logic [15:0] d, input bit w);
    logic [7:0] g = '0;
    for (int i = 0; i < 16; i++)
      if (d[i]) g ^= {(w && i >= 8) ? 2'b11 : 2'b00, TBL[i]};
    return g;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 clean, 1 single, 2 double, 3 group pattern
  task automatic do_read(input bit w, input logic [15:0] d, input logic [23:0] e,
                         input int kind, input bit tob);
    logic [15:0] dd, got;
    logic [7:0]  kk;
    dd = d ^ e[15:0];
    kk = rgen(d, w) ^ e[23:16];
    if (!w) kk[7:6] = d[1:0] ^ 2'b10;
    @(negedge clk);
    path = 2'd2; wide_chk = w; to_b = tob; snoop = 1'b0; m_in = dd; k_in = kk;
    #1;
    got = tob ? b_out : a_out;
    case (kind)
      0: chk(got == d && cerr_n && uerr_n, w ? "R3" : "R3/R2", {got, cerr_n, uerr_n}, {d, 2'b11});
      1: chk(got == d && !cerr_n && uerr_n, (e[15:0] != 0) ? "R4" : "R5",
             {got, cerr_n, uerr_n}, {d, 2'b01});
      2: chk(got == dd && cerr_n && !uerr_n, "R6", {got, cerr_n, uerr_n}, {dd, 2'b10});
      default: chk((!cerr_n || !uerr_n) && (cerr_n || uerr_n), "R7/R11",
                   {e, 6'b0, cerr_n, uerr_n}, {e, 8'h00});
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [23:0] e;
    wide_chk = 1'b0; path = 2'd2; to_b = 1'b0; snoop = 1'b1;
    a_in = '0; b_in = '0; m_in = '0; k_in = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!a_oe && !b_oe && !m_oe && !k_oe && cerr_n && uerr_n, "R9 idle",
        {a_oe, b_oe, m_oe, k_oe, cerr_n, uerr_n}, 6'b000011);

    for (int w = 0; w < 2; w++) begin
      for (int t = 0; t < 12; t++) begin
        d = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : 16'(t * 16'h9E37 + 16'h1234);
        for (int s = 0; s < 2; s++) begin
          logic [15:0] sd;
          logic [7:0]  ek;
          @(negedge clk);
          wide_chk = w[0]; path = s[1:0]; a_in = d; b_in = ~d; to_b = 1'b0; snoop = 1'b0;
          #1;
          sd = s ? ~d : d;
          ek = rgen(sd, w[0]);
          chk(m_out == sd && k_out == ek && m_oe && k_oe && !a_oe && !b_oe, "R1",
              {m_out, k_out, m_oe, k_oe, a_oe, b_oe}, {sd, ek, 4'b1100});
          if (w == 0) chk(k_out[7:6] == 2'b00, "R2", k_out, ek);
        end
        do_read(w[0], d, 24'h0, 0, t[0]);
        for (int p = 0; p < 24; p++) begin
          if (w == 0 && p >= 22) continue;
          do_read(w[0], d, 24'(1) << p, 1, t[0]);
        end
        for (int p = 0; p < 24; p++)
          for (int q = p + 1; q < 24; q++) begin
            if (w == 0 && q >= 22) continue;
            do_read(w[0], d, (24'(1) << p) | (24'(1) << q), 2, t[0]);
          end
        for (int g = 0; g < 6; g++)
          for (int v = 1; v < 16; v++) begin
            e = 24'(v) << (4 * g);
            if (w == 0) e &= 24'h3FFFFF;
            if (e == 0) continue;
            do_read(w[0], d, e, 3, t[0]);
          end
      end
    end

    // R8: read steering
    for (int tb = 0; tb < 2; tb++) begin
      @(negedge clk);
      wide_chk = 1'b1; path = 2'd2; snoop = 1'b0; to_b = tb[0];
      m_in = 16'h5A5A; k_in = rgen(16'h5A5A, 1'b1); a_in = 16'h1111; b_in = 16'h2222;
      #1;
      chk(a_oe == !tb[0] && b_oe == tb[0] && !m_oe && !k_oe &&
          (tb[0] ? b_out : a_out) == 16'h5A5A, "R8",
          {a_oe, b_oe, m_oe, k_oe, tb[0] ? b_out : a_out}, {!tb[0], tb[0], 2'b00, 16'h5A5A});
    end

    // R9: snoop still flags a repaired error
    @(negedge clk);
    path = 2'd2; snoop = 1'b1; wide_chk = 1'b0;
    m_in = 16'h0F0F ^ 16'h0100; k_in = rgen(16'h0F0F, 1'b0);
    #1;
    chk(!a_oe && !b_oe && !m_oe && !k_oe && !cerr_n && uerr_n, "R9",
        {a_oe, b_oe, m_oe, k_oe, cerr_n, uerr_n}, 6'b000001);

    // R10: user to user, with corrupt memory data present; R8 flags idle
    for (int tb = 0; tb < 2; tb++) begin
      @(negedge clk);
      path = 2'd3; snoop = 1'b0; to_b = tb[0]; a_in = 16'h1234; b_in = 16'hABCD;
      m_in = 16'h0003; k_in = 8'h00;
      #1;
      if (tb == 1)
        chk(b_out == 16'h1234 && b_oe && !a_oe && !m_oe && !k_oe, "R10 A->B",
            {b_out, b_oe, a_oe, m_oe, k_oe}, {16'h1234, 4'b1000});
      else
        chk(a_out == 16'hABCD && a_oe && !b_oe && !m_oe && !k_oe, "R10 B->A",
            {a_out, a_oe, b_oe, m_oe, k_oe}, {16'hABCD, 4'b1000});
      chk(cerr_n && uerr_n, "R8 flags idle", {cerr_n, uerr_n}, 2'b11);
    end
    @(negedge clk);
    path = 2'd0; m_in = 16'h0003; k_in = 8'h00;
    #1;
    chk(cerr_n && uerr_n, "R8 flags idle on write", {cerr_n, uerr_n}, 2'b11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule